// File: doc/BRIEF.md
# Event Time-Multiplexing Stub Distributor

This block sits on a front-end board and steers a stream of detector stub words, framed into events by first-word and last-word markers, towards a set of identical downstream processing nodes. A whole event is handed to one node. The next event goes to the next node in a fixed rotation, so that the nodes work on different events side by side in time. The node that receives an event is chosen when its first word is accepted, and that choice holds until the event's last word has been forwarded.

Each stub carries a sector number and a flag that marks it as lying on the boundary between two sectors. A flagged stub is sent twice to the same node. The first copy carries its own sector and the second carries the next sector up, wrapping from the top sector back to sector 0. The payload is forwarded unchanged whatever the destination. The block has no storage stage: an output is valid in the same cycle as the input that drives it. Back-pressure from the selected node stalls the input directly.

Top module: `tm_stub_distributor`

## Requirements
- R1: After reset every `out_valid` bit is low while no input is valid, and the first event is sent to node 0.
- R2: Every word of an event, from the word with `in_sop` to the word with `in_eop`, appears on the single node chosen when the first word was accepted.
- R3: Event k after reset goes to node k modulo NODES. The node index counts up by one per event and wraps from NODES-1 to 0.
- R4: `out_payload` equals `in_payload`, and for a stub with `in_border` low, `out_sector` equals `in_sector`, whatever the node.
- R5: A stub with `in_border` high is presented twice to the same node. The first copy carries sector s. The second carries s+1, or 0 when s is SECTORS-1, and is presented only in the cycle after the first copy was accepted. `in_ready` stays low until the second copy is accepted.
- R6: `out_sop` is high only on the first copy of a first word, and `out_eop` only on the last copy of a last word.
- R7: While the selected node holds its `out_ready` low, `in_ready` is low, and the valid bit, payload and sector on the outputs hold. No other node sees a valid word.
- R8: At most one bit of `out_valid` is high in any cycle.
- R9: A valid word without `in_sop` that arrives while no event is open is discarded. `in_ready` is high, every `out_valid` bit stays low, and the rotation does not advance.
- R10: A one-word event, with `in_sop` and `in_eop` both high, closes at once and moves the rotation on to the next node.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input stub valid |
| in_ready | output | 1 | Input stub accepted when high together with in_valid |
| in_payload | input | PAY_W | Stub content |
| in_sector | input | SEC_W | Sector number of the stub, 0 to SECTORS-1 |
| in_border | input | 1 | Stub lies on the boundary to the next sector up |
| in_sop | input | 1 | First word of an event |
| in_eop | input | 1 | Last word of an event |
| out_valid | output | NODES | One valid bit per processing node |
| out_ready | input | NODES | One ready bit per processing node |
| out_payload | output | PAY_W | Stub content shared by all node streams |
| out_sector | output | SEC_W | Sector of the copy being presented |
| out_sop | output | 1 | First copy of an event's first word |
| out_eop | output | 1 | Last copy of an event's last word |

## Verification
The assertions take for granted that the input follows valid/ready rules: a valid word and its fields hold until `in_ready` accepts it. They also assume that events are well formed, so a new `in_sop` never arrives while an event is open. They further assume that `in_sector` stays below SECTORS. The stall and duplication properties depend on that holding behaviour. The bench drives every word at a falling edge and keeps it unchanged until the copies it expects have been taken. It opens each event only after the previous one has closed, and it uses sector values inside the legal range only.

// File: rtl/tm_stub_pkg.sv
// Shared types for the event time-multiplexing stub distributor.
// Assumes nothing beyond a standard compile order (this file first).
package tm_stub_pkg;

    // Which copy of a stub is presented at the outputs.
    typedef enum logic {
        COPY_FIRST  = 1'b0,
        COPY_SECOND = 1'b1
    } copy_phase_e;

endpackage

// File: rtl/stub_node_rotor.sv
// Picks the destination node per event and rotates it over NODES.
// Assumes: start_i/end_i pulse only on the accepted final copy of a word,
// and no new start arrives while an event is open.
module stub_node_rotor #(
    parameter int NODES  = 36,
    parameter int NODE_W = (NODES > 1) ? $clog2(NODES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,    // final copy of a routed word accepted
    input  logic              sop_i,
    input  logic              eop_i,
    output logic [NODE_W-1:0] dest_o,
    output logic              open_o
);

    logic [NODE_W-1:0] next_q;
    logic [NODE_W-1:0] cur_q;
    logic              open_q;
    logic [NODE_W-1:0] next_inc;

    // Next rotation slot, wrapping at the last node.
    always_comb begin
        next_inc = (next_q == NODE_W'(NODES - 1)) ? '0 : next_q + 1'b1;
    end

    // Latch the node at event start and track whether an event is open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_q <= '0;
            cur_q  <= '0;
            open_q <= 1'b0;
        end else if (take_i) begin
            if (!open_q && sop_i) begin
                cur_q  <= next_q;
                next_q <= next_inc;
                open_q <= !eop_i;
            end else if (open_q && eop_i) begin
                open_q <= 1'b0;
            end
        end
    end

    // An open event keeps its node; otherwise the next slot is offered.
    always_comb begin
        dest_o = open_q ? cur_q : next_q;
        open_o = open_q;
    end

endmodule

// File: rtl/stub_border_dup.sv
// Sequences the one or two copies of a stub and computes each copy's sector.
// Assumes: the input word holds until its last copy is accepted.
module stub_border_dup
    import tm_stub_pkg::*;
#(
    parameter int SECTORS = 8,
    parameter int SEC_W   = (SECTORS > 1) ? $clog2(SECTORS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire_i,     // current copy accepted downstream
    input  logic             border_i,
    input  logic [SEC_W-1:0] sector_i,
    output logic [SEC_W-1:0] sector_o,
    output logic             first_o,
    output logic             last_o
);

    copy_phase_e phase_q;
    logic [SEC_W-1:0] sector_up;

    // Neighbouring sector, wrapping from the top sector to 0.
    always_comb begin
        sector_up = (sector_i == SEC_W'(SECTORS - 1)) ? '0 : sector_i + 1'b1;
    end

    // Step from the first to the second copy of a border stub.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= COPY_FIRST;
        end else if (fire_i) begin
            phase_q <= (border_i && phase_q == COPY_FIRST) ? COPY_SECOND : COPY_FIRST;
        end
    end

    // Copy position and sector of the copy on the outputs.
    always_comb begin
        first_o  = (phase_q == COPY_FIRST);
        last_o   = !border_i || (phase_q == COPY_SECOND);
        sector_o = (phase_q == COPY_SECOND) ? sector_up : sector_i;
    end

endmodule

// File: rtl/stub_out_demux.sv
// Turns a node index into one valid bit per node and selects that node's ready.
// Assumes dest_i < NODES.
module stub_out_demux #(
    parameter int NODES  = 36,
    parameter int NODE_W = (NODES > 1) ? $clog2(NODES) : 1
) (
    input  logic              active_i,
    input  logic [NODE_W-1:0] dest_i,
    input  logic [NODES-1:0]  ready_i,
    output logic [NODES-1:0]  valid_o,
    output logic              sel_ready_o
);

    // One decoded valid per node stream.
    for (genvar i = 0; i < NODES; i++) begin : g_node
        assign valid_o[i] = active_i && (dest_i == NODE_W'(i));
    end

    // Ready of the node currently addressed.
    always_comb begin
        sel_ready_o = |(ready_i & valid_o);
    end

endmodule

// File: rtl/tm_stub_distributor.sv
// Event time-multiplexing stub distributor: whole events rotate over NODES
// identical node streams, and border stubs are emitted twice (sector s, s+1).
// Assumes valid/ready-compliant input and well-formed sop/eop framing.
module tm_stub_distributor #(
    parameter int NODES   = 36,
    parameter int SECTORS = 8,
    parameter int PAY_W   = 32,
    localparam int SEC_W  = (SECTORS > 1) ? $clog2(SECTORS) : 1,
    localparam int NODE_W = (NODES > 1) ? $clog2(NODES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [PAY_W-1:0] in_payload,
    input  logic [SEC_W-1:0] in_sector,
    input  logic             in_border,
    input  logic             in_sop,
    input  logic             in_eop,
    output logic [NODES-1:0] out_valid,
    input  logic [NODES-1:0] out_ready,
    output logic [PAY_W-1:0] out_payload,
    output logic [SEC_W-1:0] out_sector,
    output logic             out_sop,
    output logic             out_eop
);

    logic [NODE_W-1:0] dest;
    logic              evt_open;
    logic              active;
    logic              sel_ready;
    logic              fire;
    logic              copy_first;
    logic              copy_last;
    logic              take;

    // A word is routed if it belongs to an open event or starts one.
    always_comb begin
        active   = in_valid && (evt_open || in_sop);
        fire     = active && sel_ready;
        take     = fire && copy_last;
        in_ready = !active || (sel_ready && copy_last);
    end

    stub_node_rotor #(.NODES(NODES), .NODE_W(NODE_W)) u_rotor (
        .clk    (clk),
        .rst_n  (rst_n),
        .take_i (take),
        .sop_i  (in_sop),
        .eop_i  (in_eop),
        .dest_o (dest),
        .open_o (evt_open)
    );

    stub_border_dup #(.SECTORS(SECTORS), .SEC_W(SEC_W)) u_dup (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire_i   (fire),
        .border_i (in_border),
        .sector_i (in_sector),
        .sector_o (out_sector),
        .first_o  (copy_first),
        .last_o   (copy_last)
    );

    stub_out_demux #(.NODES(NODES), .NODE_W(NODE_W)) u_demux (
        .active_i    (active),
        .dest_i      (dest),
        .ready_i     (out_ready),
        .valid_o     (out_valid),
        .sel_ready_o (sel_ready)
    );

    // Shared data bus and framing flags per copy.
    always_comb begin
        out_payload = in_payload;
        out_sop     = in_sop && copy_first;
        out_eop     = in_eop && copy_last;
    end

endmodule

// File: rtl/tm_stub_distributor_chk.sv
// Property checker for tm_stub_distributor, attached by bind below.
// Assumes valid/ready-compliant, well-framed input with legal sectors.
module tm_stub_distributor_chk #(
    parameter int NODES   = 36,
    parameter int SECTORS = 8,
    parameter int PAY_W   = 32,
    localparam int SEC_W  = (SECTORS > 1) ? $clog2(SECTORS) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             in_sop,
    input logic             in_border,
    input logic             evt_open,
    input logic [NODES-1:0] out_valid,
    input logic [NODES-1:0] out_ready,
    input logic [PAY_W-1:0] out_payload,
    input logic [SEC_W-1:0] out_sector,
    input logic             out_eop
);

    logic             out_fire;
    logic             mid_q;
    logic [NODES-1:0] mask_q;
    logic [SEC_W-1:0] up_q;

    // Any node accepted a copy this cycle.
    always_comb begin
        out_fire = |(out_valid & out_ready);
    end

    // Remember the node of the event in flight and the sector above the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mid_q  <= 1'b0;
            mask_q <= '0;
            up_q   <= '0;
        end else begin
            if (out_fire) begin
                mid_q  <= !out_eop;
                mask_q <= out_valid;
            end
            up_q <= (out_sector == SEC_W'(SECTORS - 1)) ? '0 : out_sector + 1'b1;
        end
    end

    // R8
    one_node_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_valid));

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(out_valid & ~out_ready)) |=>
            (out_valid == $past(out_valid)) && $stable(out_payload) && $stable(out_sector));

    // R5
    dup_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_border && out_fire && !in_ready) |=>
            (out_valid == $past(out_valid)) && (out_sector == up_q));

    // R2
    same_node_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mid_q && (|out_valid)) |-> (out_valid == mask_q));

    // R9
    idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_sop && !evt_open) |-> (out_valid == '0) && in_ready);

endmodule

bind tm_stub_distributor tm_stub_distributor_chk #(
    .NODES(NODES), .SECTORS(SECTORS), .PAY_W(PAY_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_sop      (in_sop),
    .in_border   (in_border),
    .evt_open    (evt_open),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_payload (out_payload),
    .out_sector  (out_sector),
    .out_eop     (out_eop)
);

// File: tb/tm_stub_distributor_test.sv
// Directed bench for tm_stub_distributor: one task per scenario.
module tm_stub_distributor_test;

    localparam int N  = 5;
    localparam int SC = 8;
    localparam int PW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [PW-1:0] in_payload = '0;
    logic [2:0]    in_sector = '0;
    logic          in_border = 1'b0;
    logic          in_sop = 1'b0;
    logic          in_eop = 1'b0;
    logic [N-1:0]  out_valid;
    logic [N-1:0]  out_ready = '1;
    logic [PW-1:0] out_payload;
    logic [2:0]    out_sector;
    logic          out_sop;
    logic          out_eop;

    int total = 0;
    int bad = 0;
    int exp_node = 0;

    always #4 clk = ~clk;

    tm_stub_distributor #(.NODES(N), .SECTORS(SC), .PAY_W(PW)) uut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_payload(in_payload),
        .in_sector(in_sector), .in_border(in_border), .in_sop(in_sop), .in_eop(in_eop),
        .out_valid(out_valid), .out_ready(out_ready), .out_payload(out_payload),
        .out_sector(out_sector), .out_sop(out_sop), .out_eop(out_eop)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one word at a falling edge and check each copy before the next rising edge.
    task automatic push(input logic [PW-1:0] p, input int s, input bit b,
                        input bit so, input bit eo, input bit fwd, input int node);
        int ncopy;
        @(negedge clk);
        in_valid = 1'b1; in_payload = p; in_sector = 3'(s);
        in_border = b; in_sop = so; in_eop = eo;
        ncopy = (fwd && b) ? 2 : 1;
        for (int c = 0; c < ncopy; c++) begin
            #3;
            if (!fwd) begin
                check(out_valid == '0, "R9 discard valid", out_valid, 0);
                check(in_ready == 1'b1, "R9 discard ready", in_ready, 1);
            end else begin
                check(out_valid == N'(1 << node), "R2/R3 node", out_valid, 1 << node);
                check(out_payload == p, "R4 payload", out_payload, p);
                check(out_sector == 3'((s + c) % SC), "R4/R5 sector", out_sector, (s + c) % SC);
                check(out_sop == (so && c == 0), "R6 sop", out_sop, so && c == 0);
                check(out_eop == (eo && c == ncopy - 1), "R6 eop", out_eop, eo && c == ncopy - 1);
                check(in_ready == (c == ncopy - 1), "R5 in_ready", in_ready, c == ncopy - 1);
            end
            @(negedge clk);
        end
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_border = 1'b0;
    endtask

    // Send an event of plain words to the node next in rotation.
    task automatic send_event(input int words, input logic [PW-1:0] base, input int s);
        for (int w = 0; w < words; w++)
            push(base + PW'(w), s, 1'b0, w == 0, w == words - 1, 1'b1, exp_node);
        exp_node = (exp_node + 1) % N;
    endtask

    task automatic t_reset();
        @(negedge clk); #3;
        check(out_valid == '0, "R1 idle valid", out_valid, 0);
        check(in_ready == 1'b1, "R1 idle ready", in_ready, 1);
        send_event(1, 32'hA000_0000, 1);   // R1: first event on node 0
    endtask

    task automatic t_multi_event();
        send_event(3, 32'hB100_0000, 2);   // R2 R3
        send_event(4, 32'hB200_0000, 5);
        send_event(2, 32'hB300_0000, 0);
    endtask

    task automatic t_wrap();
        for (int e = 0; e < N + 2; e++) send_event(1, 32'hC000_0000 + PW'(e), e % SC); // R10 R3
    endtask

    task automatic t_border();
        push(32'hD000_0001, 2, 1'b1, 1'b1, 1'b0, 1'b1, exp_node);   // R5
        push(32'hD000_0002, 7, 1'b1, 1'b0, 1'b0, 1'b1, exp_node);   // R5 wrap
        push(32'hD000_0003, 4, 1'b1, 1'b0, 1'b1, 1'b1, exp_node);   // R6
        exp_node = (exp_node + 1) % N;
        push(32'hD000_0004, 6, 1'b1, 1'b1, 1'b1, 1'b1, exp_node);
        exp_node = (exp_node + 1) % N;
    endtask

    task automatic t_stall();
        out_ready = ~N'(1 << exp_node);
        @(negedge clk);
        in_valid = 1'b1; in_payload = 32'hE0E0_0001; in_sector = 3'd3;
        in_border = 1'b0; in_sop = 1'b1; in_eop = 1'b1;
        for (int k = 0; k < 3; k++) begin
            #3;
            check(in_ready == 1'b0, "R7 stall ready", in_ready, 0);
            check(out_valid == N'(1 << exp_node), "R7 stall node", out_valid, 1 << exp_node);
            check(out_payload == 32'hE0E0_0001, "R7 stall payload", out_payload, 32'hE0E0_0001);
            @(negedge clk);
        end
        out_ready = '1;
        #3;
        check(in_ready == 1'b1, "R7 release", in_ready, 1);
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        exp_node = (exp_node + 1) % N;
        send_event(1, 32'hE0E0_0002, 1);   // R3 rotation after stall
    endtask

    task automatic t_idle_drop();
        push(32'hF000_0001, 3, 1'b0, 1'b0, 1'b0, 1'b0, 0);   // R9
        push(32'hF000_0002, 3, 1'b1, 1'b0, 1'b1, 1'b0, 0);   // R9
        send_event(2, 32'hF100_0000, 4);   // R9: rotation did not advance
    endtask

    initial begin
        #(8 * 100000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_multi_event();
        t_wrap();
        t_border();
        t_stall();
        t_idle_drop();
        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule